// File: doc/BRIEF.md
# Periodic Timeout Interrupt Generator

This block produces a timeout flag, and an interrupt request that depends on it, at a fixed periodic rate. Its base tick comes from one of two places, chosen by a mode input. In standard mode the tick is a tap of an internal free-running counter that advances on a system clock enable. In alternate mode the tick is the underflow pulse of an external modulus prescaler. That prescaler runs from the crystal, so in this mode the interrupt rate does not follow changes in bus speed. A power-of-two divider, set by a 2-bit rate code, stretches the chosen tick. The available divisors depend on the mode.

Timeouts are spaced by a constant number of ticks. Each period is measured from the previous timeout. Software latency in clearing the flag therefore never shifts the period. Software clears the flag with a one-cycle strobe. The interrupt request is a level that follows the flag while the enable bit is set. The block has no data stream, so all of its pins are plain control and status lines with no handshake.

Top module: `periodic_irq_gen`

## Requirements
- R1: With `pll_mode` low, the base tick fires once for every 2^FRC_W cycles in which `sys_tick_en` is high. With rate code 00, the first flag appears 2^FRC_W enabled cycles after reset is released.
- R2: With `pll_mode` high, the base tick is exactly the `presc_uflow` pulse. The free-running counter tap has no influence on when timeouts occur.
- R3: In standard mode, rate codes 00, 01, 10 and 11 divide the tick by 1, 2, 4 and 2^STD_TOP_SH. With the default of 3, this gives periods of 2^FRC_W times 1, 2, 4 and 8.
- R4: In alternate mode, rate codes 00, 01, 10 and 11 divide the underflow pulses by 1, 2, 4 and 2^ALT_TOP_SH. The default of 6 gives a last divisor of 64.
- R5: Each timeout sets `tmo_flag` on the following cycle. Only a timeout can set it.
- R6: A one-cycle `flag_clr` clears the flag on the next cycle. If a clear and a timeout occur in the same cycle, the flag stays set.
- R7: `irq_req` is high exactly while both `tmo_flag` and `irq_en` are high, as a level.
- R8: The spacing between timeouts is constant and is measured from the previous timeout. It does not depend on when the flag is cleared.
- R9: After reset, one full period elapses before the flag is set for the first time. Reset clears the divider, the flag and the free-running counter.
- R10: A change to the rate code or mode takes effect on the next tick without clearing the divider. If the count has already reached the new terminal value, that next tick is a timeout.
- R11: While `sys_tick_en` is low, the free-running counter holds its value, which delays the standard-mode tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pll_mode | input | 1 | 0: free-running counter tick, 1: prescaler underflow tick |
| sys_tick_en | input | 1 | Advance enable for the free-running counter |
| presc_uflow | input | 1 | Single-cycle underflow pulse from the modulus prescaler |
| rate_sel | input | 2 | Divider code (see R3, R4) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Single-cycle flag clear strobe |
| tmo_flag | output | 1 | Timeout flag |
| irq_req | output | 1 | Interrupt request level |

## Verification
The bench builds the block with FRC_W = 4. This makes a standard-mode tick every 16 enabled cycles, so all four standard periods, the longest being 128 cycles, run for several timeouts each in a short run. STD_TOP_SH and ALT_TOP_SH keep their defaults of 3 and 6. With an underflow pulse every 5 cycles, the 64-pulse alternate period takes 320 cycles, so the largest divisor is also observed end to end. The short periods also let the bench place a clear exactly on a timeout cycle and change the rate code in the middle of a count.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // Rate code meaning: 00 /1, 01 /2, 10 /4, 11 /mode-specific top divisor
  typedef enum logic [1:0] {
    RATE_DIV1 = 2'b00,
    RATE_DIV2 = 2'b01,
    RATE_DIV4 = 2'b10,
    RATE_DTOP = 2'b11
  } rate_code_e;

  typedef enum logic {
    SRC_FRC  = 1'b0,
    SRC_PRES = 1'b1
  } tick_src_e;

  // Shift amount selected by a rate code, given the mode's top shift
  function automatic int unsigned code_shift(input int unsigned code,
                                             input int unsigned top_sh);
    return (code == 3) ? top_sh : code;
  endfunction

endpackage

// File: rtl/pirq_frc.sv
// Free-running counter; emits a one-cycle tap each time it wraps.
module pirq_frc #(
  parameter int unsigned FRC_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_en,
  output logic tap
);
  logic [FRC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (adv_en) cnt_q <= cnt_q + 1'b1;
  end

  assign tap = adv_en && (&cnt_q);
endmodule

// File: rtl/pirq_div.sv
// Power-of-two tick divider. The terminal count is chosen per tick, so a
// rate change applies at the next tick and never clears the count.
module pirq_div
  import pirq_pkg::*;
#(
  parameter int unsigned STD_TOP_SH = 3,
  parameter int unsigned ALT_TOP_SH = 6,
  localparam int unsigned MAX_SH = (ALT_TOP_SH > STD_TOP_SH) ? ALT_TOP_SH : STD_TOP_SH,
  localparam int unsigned CNT_W  = (MAX_SH > 0) ? MAX_SH : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       alt_mode,
  input  logic [1:0] rate_sel,
  output logic       timeout
);
  logic [CNT_W-1:0] term_std [4];
  logic [CNT_W-1:0] term_alt [4];
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] cnt_q;
  logic             at_term;

  for (genvar g = 0; g < 4; g++) begin : g_term
    localparam int unsigned SH_S = code_shift(g, STD_TOP_SH);
    localparam int unsigned SH_A = code_shift(g, ALT_TOP_SH);
    assign term_std[g] = CNT_W'((64'd1 << SH_S) - 64'd1);
    assign term_alt[g] = CNT_W'((64'd1 << SH_A) - 64'd1);
  end

  always_comb begin
    if (tick_src_e'(alt_mode) == SRC_PRES) term = term_alt[rate_sel];
    else                                   term = term_std[rate_sel];
  end

  // ">=" lets a count already past a smaller new terminal expire at once
  assign at_term = (cnt_q >= term);
  assign timeout = tick && at_term;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (timeout) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pirq_flag.sv
// Timeout flag with timeout-over-clear priority and a gated request level.
module pirq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_pulse,
  input  logic clr_pulse,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)            flag <= 1'b0;
    else if (set_pulse) flag <= 1'b1;
    else if (clr_pulse) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pirq_pkg::*;
#(
  parameter int unsigned FRC_W      = 15,
  parameter int unsigned STD_TOP_SH = 3,
  parameter int unsigned ALT_TOP_SH = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_mode,
  input  logic       sys_tick_en,
  input  logic       presc_uflow,
  input  logic [1:0] rate_sel,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       tmo_flag,
  output logic       irq_req
);
  logic frc_tap;
  logic div_tick;
  logic div_tmo;

  pirq_frc #(.FRC_W(FRC_W)) frc_i (
    .clk    (clk),
    .rst    (rst),
    .adv_en (sys_tick_en),
    .tap    (frc_tap)
  );

  always_comb begin
    unique case (tick_src_e'(pll_mode))
      SRC_PRES: div_tick = presc_uflow;
      default:  div_tick = frc_tap;
    endcase
  end

  pirq_div #(.STD_TOP_SH(STD_TOP_SH), .ALT_TOP_SH(ALT_TOP_SH)) div_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (div_tick),
    .alt_mode (pll_mode),
    .rate_sel (rate_sel),
    .timeout  (div_tmo)
  );

  pirq_flag flag_i (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (div_tmo),
    .clr_pulse (flag_clr),
    .irq_en    (irq_en),
    .flag      (tmo_flag),
    .irq       (irq_req)
  );
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk (
  input logic clk,
  input logic rst,
  input logic pll_mode,
  input logic frc_tap,
  input logic presc_uflow,
  input logic timeout,
  input logic flag_clr,
  input logic irq_en,
  input logic tmo_flag,
  input logic irq_req
);
  a_r5_timeout_sets_flag: assert property (@(posedge clk) disable iff (rst)
    timeout |=> tmo_flag);

  a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!tmo_flag && !timeout) |=> !tmo_flag);

  a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !timeout) |=> !tmo_flag);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq_req);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    !tmo_flag |-> !irq_req);

  a_r1_std_source: assert property (@(posedge clk) disable iff (rst)
    (!pll_mode && timeout) |-> frc_tap);

  a_r2_alt_source: assert property (@(posedge clk) disable iff (rst)
    (pll_mode && timeout) |-> presc_uflow);
endmodule

bind periodic_irq_gen pirq_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .pll_mode    (pll_mode),
  .frc_tap     (frc_tap),
  .presc_uflow (presc_uflow),
  .timeout     (div_tmo),
  .flag_clr    (flag_clr),
  .irq_en      (irq_en),
  .tmo_flag    (tmo_flag),
  .irq_req     (irq_req)
);

// File: tb/periodic_irq_gen_tb_top.sv
`timescale 1ns/1ps
module periodic_irq_gen_tb_top;
  localparam int FRC_W  = 4;
  localparam int STD_P  = 1 << FRC_W;
  localparam int UF_GAP = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       pll_mode = 1'b0;
  logic       sys_tick_en = 1'b1;
  logic       presc_uflow = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       irq_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       tmo_flag, irq_req;
  logic       uf_on = 1'b0;

  periodic_irq_gen #(.FRC_W(FRC_W)) dut_i (
    .clk(clk), .rst(rst), .pll_mode(pll_mode), .sys_tick_en(sys_tick_en),
    .presc_uflow(presc_uflow), .rate_sel(rate_sel), .irq_en(irq_en),
    .flag_clr(flag_clr), .tmo_flag(tmo_flag), .irq_req(irq_req)
  );

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Underflow pulse lands on every edge whose index is a multiple of UF_GAP
  always @(negedge clk)
    presc_uflow <= uf_on && ((cyc + 1) % UF_GAP == 0);

  typedef struct { int at; string tag; } exp_t;
  exp_t sb_q[$];
  exp_t mon_e;
  int   n_chk = 0, n_err = 0;
  logic mon_en = 1'b0;
  logic flag_q = 1'b0;

  // Monitor: every rising flag must match the next expected timeout cycle
  always @(negedge clk) begin
    if (rst || !mon_en) flag_q = 1'b0;
    else begin
      if (tmo_flag && !flag_q) begin
        n_chk++;
        if (sb_q.size() == 0) begin
          n_err++;
          $display("FAIL unexpected flag rise: got cycle %0d, expected none", cyc);
        end else begin
          mon_e = sb_q.pop_front();
          if (mon_e.at != cyc) begin
            n_err++;
            $display("FAIL %s: flag rise at cycle %0d, expected %0d", mon_e.tag, cyc, mon_e.at);
          end
        end
      end
      flag_q = tmo_flag;
    end
  end

  task automatic chk(input string tag, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: got %b, expected %b", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mon_en = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; mon_en = 1'b1;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    while (sb_q.size() > 0) begin
      mon_e = sb_q.pop_front();
      n_chk++; n_err++;
      $display("FAIL %s: flag rise missing, got none, expected cycle %0d", tag, mon_e.at);
    end
  endtask

  // Driver: push expected timeouts, clear the flag dly cycles after each one
  task automatic run_case(input logic mode, input logic [1:0] rate, input int per,
                          input int npers, input string tag, input int dly);
    int cd;
    logic was;
    pll_mode = mode; rate_sel = rate; uf_on = mode; sys_tick_en = 1'b1;
    do_reset();
    for (int k = 1; k <= npers; k++) sb_q.push_back('{k * per, tag});
    cd = 0;
    while (sb_q.size() > 0 && cyc < per * (npers + 1)) begin
      @(negedge clk);
      was = flag_clr;
      flag_clr = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) flag_clr = 1'b1;
      end else if (tmo_flag && !was) cd = dly;
    end
    drain(tag);
  endtask

  initial begin
    // Reset state
    irq_en = 1'b1;
    do_reset();
    chk("R9 flag low after reset", tmo_flag, 1'b0);
    chk("R7 irq low after reset", irq_req, 1'b0);

    // R1 R3 R8 R9: standard mode, each rate code, varied clear latency
    run_case(1'b0, 2'b00, STD_P,     3, "R1", 1);
    run_case(1'b0, 2'b01, STD_P * 2, 3, "R3 div2", 5);
    run_case(1'b0, 2'b10, STD_P * 4, 3, "R8 div4", 17);
    run_case(1'b0, 2'b11, STD_P * 8, 3, "R3 div8", 90);

    // R2 R4: alternate mode, divisors 1, 2, 4, 64 of the underflow pulse
    run_case(1'b1, 2'b00, UF_GAP,      4, "R2", 2);
    run_case(1'b1, 2'b01, UF_GAP * 2,  3, "R4 div2", 3);
    run_case(1'b1, 2'b10, UF_GAP * 4,  3, "R4 div4", 7);
    run_case(1'b1, 2'b11, UF_GAP * 64, 2, "R4 div64", 100);
    uf_on = 1'b0;

    // R6 R7: clear on the timeout cycle, then irq gating by enable
    pll_mode = 1'b0; rate_sel = 2'b00; irq_en = 1'b1;
    do_reset();
    sb_q.push_back('{STD_P, "R6"});
    sb_q.push_back('{3 * STD_P, "R6"});
    wait_to(20);
    chk("R7 irq with flag and enable", irq_req, 1'b1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R7 irq masked by enable", irq_req, 1'b0);
    chk("R7 flag kept while masked", tmo_flag, 1'b1);
    wait_to(25);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq returns with enable", irq_req, 1'b1);
    wait_to(2 * STD_P - 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R6 timeout wins over clear", tmo_flag, 1'b1);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R6 clear strobe clears flag", tmo_flag, 1'b0);
    chk("R7 irq drops with flag", irq_req, 1'b0);
    wait_to(3 * STD_P + 1);
    drain("R6");

    // R10: rate change mid-count (div8 -> div2 with count already 5)
    pll_mode = 1'b0; rate_sel = 2'b11;
    do_reset();
    sb_q.push_back('{6 * STD_P, "R10"});
    sb_q.push_back('{8 * STD_P, "R10"});
    wait_to(5 * STD_P + 5);
    rate_sel = 2'b01;
    wait_to(6 * STD_P + 4);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_to(8 * STD_P + 2);
    drain("R10");

    // R11: counter enable held low for edges 5..14 shifts the tick by 10
    pll_mode = 1'b0; rate_sel = 2'b00;
    do_reset();
    sb_q.push_back('{STD_P + 10, "R11"});
    sb_q.push_back('{2 * STD_P + 10, "R11"});
    wait_to(4);
    sys_tick_en = 1'b0;
    wait_to(14);
    sys_tick_en = 1'b1;
    wait_to(STD_P + 9);
    chk("R11 no flag before stalled period ends", tmo_flag, 1'b0);
    wait_to(STD_P + 14);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_to(2 * STD_P + 12);
    drain("R11");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not complete, got timeout, expected end");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule